// File: doc/BRIEF.md
# Floating-Point Divide Special-Operand and Status Stage

This block is the front and status stage of a floating-point divide unit. It receives a dividend (the destination operand) and a divisor (the source operand), both already widened to one common extended format. The format is a sign bit, an exponent field and a mantissa with an explicit integer bit. The block sorts each operand into one of four classes: in-range, zero, infinity or NaN. When the class pair alone fixes the quotient, the block produces that quotient itself. When both operands are in range, it raises a request for the iterative mantissa divider instead.

For every accepted operation the block also builds an 8-bit exception byte and four condition-code bits. It ORs a condensed form of the exception bits into a sticky accrued-exception register. Overflow, underflow and rounding-inexact come from the rounding stage downstream and are folded in only when the divider is used. Decimal-conversion inexactness is folded in when the source was packed decimal.

The stage is a single register with a valid/ready handshake, so a result appears one cycle after acceptance. While the consumer stalls, the result is held.

Top module: `fdiv_exc_stage`

## Requirements
- R1: Class rules: exponent all ones with a zero fraction (bits below the integer bit) is infinity; all ones with a nonzero fraction is NaN; exponent zero with an all-zero mantissa is zero; everything else is in-range. Two in-range operands give out_core_req=1 and out_result=0, with OVFL (bit 4), UNFL (bit 3) and INEX2 (bit 1) copied from core_ovfl, core_unfl and core_inex2.
- R2: An in-range dividend over a zero divisor gives infinity (exponent all ones, mantissa zero) with sign equal to the XOR of the operand signs, and sets DZ (bit 2).
- R3: Zero over zero and infinity over infinity give the default NaN (sign 0, exponent all ones, mantissa top two bits 1, rest 0) and set OPERR (bit 5).
- R4: An in-range or zero dividend over an infinite divisor, and a zero dividend over an in-range divisor, give a zero with the XOR sign.
- R5: An infinite dividend over an in-range or zero divisor gives an infinity with the XOR sign, and DZ stays clear.
- R6: If either operand is NaN, the result is the dividend NaN when it is one, otherwise the divisor NaN, with the quiet bit (mantissa bit MAN_W-2) forced to 1. SNAN (bit 6) is set when either operand is a NaN with its quiet bit clear.
- R7: BSUN (bit 7) is always 0. DZ is set only for the R2 case. OVFL, UNFL and INEX2 are 0 whenever out_core_req is 0.
- R8: INEX1 (bit 0) equals src_packed AND src_dec_inexact for every operation.
- R9: out_cc is {N,Z,I,NAN} (bit 3 down to bit 0). N is the result sign (the XOR sign for a divider request). Z, I and NAN flag a zero, infinite or NaN result, and are all 0 for a divider request.
- R10: out_accrued is {IOP,OVFL,UNFL,DZ,INEX} (bit 4 down to bit 0). Reset clears it, and each accepted operation ORs in IOP=SNAN|OPERR, OVFL=OVFL, UNFL=UNFL|INEX2, DZ=DZ and INEX=INEX1|INEX2|OVFL.
- R11: in_ready = !out_valid || out_ready. An operation accepted at a clock edge is presented at that edge. Outputs and out_valid hold while out_valid && !out_ready. After reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Stage can accept |
| src_op | input | 1+EXP_W+MAN_W | Divisor, extended format |
| dst_op | input | 1+EXP_W+MAN_W | Dividend, extended format |
| src_packed | input | 1 | Divisor came from packed decimal |
| src_dec_inexact | input | 1 | Decimal conversion was inexact |
| core_ovfl | input | 1 | Overflow from rounding stage |
| core_unfl | input | 1 | Underflow from rounding stage |
| core_inex2 | input | 1 | Rounding inexact from rounding stage |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_core_req | output | 1 | Mantissa divider must compute quotient |
| out_result | output | 1+EXP_W+MAN_W | Special-case quotient |
| out_exc | output | 8 | Exception byte |
| out_cc | output | 4 | Condition codes N,Z,I,NAN |
| out_accrued | output | 5 | Sticky accrued exceptions |

## Verification
The bench sweeps all sixteen dividend/divisor class pairs with both signs. It then runs random pairs with random core and decimal flags. A design that mixed up the two operands would flag DZ for a zero dividend instead of a zero divisor, or return zero where it should return infinity. Both NaN orders are sent with quiet and signaling NaNs, so choosing the divisor NaN first or leaving the quiet bit clear shows up in out_result and in SNAN. Core flags are held high on special pairs to catch leakage into OVFL, UNFL and INEX2. A stall test offers a second pair while the output is blocked, which catches a register that drops or overwrites a held result.

// File: rtl/fdiv_exc_pkg.sv
// Package: shared types for the divide special-operand stage.
// Assumes operands already widened to one extended format.
package fdiv_exc_pkg;
    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } opclass_e;

    localparam int EXC_W = 8;
    localparam int ACC_W = 5;
    localparam int CC_W  = 4;
endpackage

// File: rtl/fdiv_operand_class.sv
// Module: sorts one extended operand into in-range / zero / infinity / NaN
// and reports whether a NaN is signaling (quiet bit clear).
// Assumes explicit integer bit at mantissa MSB; quiet bit just below it.
module fdiv_operand_class
    import fdiv_exc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int OP_W = 1 + EXP_W + MAN_W
) (
    input  logic [OP_W-1:0] op,
    output opclass_e        cls,
    output logic            signaling
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = op[MAN_W +: EXP_W];
    assign man_f = op[MAN_W-1:0];

    // Decode class from exponent and fraction fields.
    always_comb begin
        cls = CLS_NORM;
        if (&exp_f) begin
            cls = (man_f[MAN_W-2:0] == '0) ? CLS_INF : CLS_NAN;
        end else if ((exp_f == '0) && (man_f == '0)) begin
            cls = CLS_ZERO;
        end
        signaling = (cls == CLS_NAN) && !man_f[MAN_W-2];
    end
endmodule

// File: rtl/fdiv_special_table.sv
// Module: resolves the quotient for special class pairs, or requests the
// mantissa divider when both operands are in range. Purely combinational.
// Assumes the dividend is dst and the divisor is src.
module fdiv_special_table
    import fdiv_exc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int OP_W = 1 + EXP_W + MAN_W
) (
    input  logic [OP_W-1:0] src,
    input  logic [OP_W-1:0] dst,
    input  opclass_e        src_cls,
    input  opclass_e        dst_cls,
    input  logic            src_sig,
    input  logic            dst_sig,
    output logic [OP_W-1:0] result,
    output logic            core_req,
    output logic            snan,
    output logic            operr,
    output logic            dz,
    output opclass_e        res_cls,
    output logic            res_sign
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [OP_W-1:0] DEF_NAN = {1'b0, EXP_MAX, 2'b11, {(MAN_W-2){1'b0}}};

    logic xs;
    assign xs = src[OP_W-1] ^ dst[OP_W-1];

    // Select the quotient and primary flags by class pair.
    always_comb begin
        result   = '0;
        core_req = 1'b0;
        snan     = 1'b0;
        operr    = 1'b0;
        dz       = 1'b0;
        res_cls  = CLS_NORM;
        res_sign = xs;
        if ((dst_cls == CLS_NAN) || (src_cls == CLS_NAN)) begin
            snan = ((dst_cls == CLS_NAN) && dst_sig) || ((src_cls == CLS_NAN) && src_sig);
            result = (dst_cls == CLS_NAN) ? dst : src;
            result[MAN_W-2] = 1'b1;
            res_cls  = CLS_NAN;
            res_sign = result[OP_W-1];
        end else if ((dst_cls == CLS_NORM) && (src_cls == CLS_NORM)) begin
            core_req = 1'b1;
        end else if ((dst_cls == CLS_NORM) && (src_cls == CLS_ZERO)) begin
            result  = {xs, EXP_MAX, {MAN_W{1'b0}}};
            res_cls = CLS_INF;
            dz      = 1'b1;
        end else if (((dst_cls == CLS_ZERO) && (src_cls == CLS_ZERO)) ||
                     ((dst_cls == CLS_INF) && (src_cls == CLS_INF))) begin
            result   = DEF_NAN;
            res_cls  = CLS_NAN;
            res_sign = 1'b0;
            operr    = 1'b1;
        end else if ((src_cls == CLS_INF) || (dst_cls == CLS_ZERO)) begin
            result  = {xs, {(OP_W-1){1'b0}}};
            res_cls = CLS_ZERO;
        end else begin
            result  = {xs, EXP_MAX, {MAN_W{1'b0}}};
            res_cls = CLS_INF;
        end
    end

    // Check that the table never mixes exclusive outcomes.
    always_comb begin
        // R3
        dz_operr_excl_chk: assert (!(dz && operr));
        // R1
        core_no_flag_chk: assert (!(core_req && (snan || operr || dz)));
    end
endmodule

// File: rtl/fdiv_status_pack.sv
// Module: packs exception byte, condition codes and the accrued increment.
// Assumes rounding-stage flags matter only when the divider is requested.
module fdiv_status_pack
    import fdiv_exc_pkg::*;
(
    input  logic             core_req,
    input  logic             snan,
    input  logic             operr,
    input  logic             dz,
    input  logic             core_ovfl,
    input  logic             core_unfl,
    input  logic             core_inex2,
    input  logic             src_packed,
    input  logic             src_dec_inexact,
    input  opclass_e         res_cls,
    input  logic             res_sign,
    output logic [EXC_W-1:0] exc,
    output logic [CC_W-1:0]  cc,
    output logic [ACC_W-1:0] acc_inc
);
    logic ovfl, unfl, inex2, inex1;

    // Gate rounding flags and form the exception byte.
    always_comb begin
        ovfl  = core_req & core_ovfl;
        unfl  = core_req & core_unfl;
        inex2 = core_req & core_inex2;
        inex1 = src_packed & src_dec_inexact;
        exc   = {1'b0, snan, operr, ovfl, unfl, dz, inex2, inex1};
    end

    // Condition codes from the result class and sign.
    always_comb begin
        cc = {res_sign, res_cls == CLS_ZERO, res_cls == CLS_INF, res_cls == CLS_NAN};
    end

    // Condensed sticky bits for the accrued register.
    always_comb begin
        acc_inc = {snan | operr, ovfl, unfl | inex2, dz, inex1 | inex2 | ovfl};
    end
endmodule

// File: rtl/fdiv_exc_stage.sv
// Module: top of the divide special-operand and status stage. Classifies
// both operands, resolves special quotients, packs status, and registers
// all of it behind a one-deep valid/ready stage with a sticky accrued byte.
// Assumes rounding flags are presented alongside the operand pair.
module fdiv_exc_stage
    import fdiv_exc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int OP_W = 1 + EXP_W + MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  src_op,
    input  logic [OP_W-1:0]  dst_op,
    input  logic             src_packed,
    input  logic             src_dec_inexact,
    input  logic             core_ovfl,
    input  logic             core_unfl,
    input  logic             core_inex2,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_core_req,
    output logic [OP_W-1:0]  out_result,
    output logic [EXC_W-1:0] out_exc,
    output logic [CC_W-1:0]  out_cc,
    output logic [ACC_W-1:0] out_accrued
);
    opclass_e         src_cls, dst_cls, res_cls;
    logic             src_sig, dst_sig, res_sign;
    logic [OP_W-1:0]  result;
    logic             core_req, snan, operr, dz, fire;
    logic [EXC_W-1:0] exc;
    logic [CC_W-1:0]  cc;
    logic [ACC_W-1:0] acc_inc;

    fdiv_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_src_cls (
        .op(src_op), .cls(src_cls), .signaling(src_sig)
    );
    fdiv_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dst_cls (
        .op(dst_op), .cls(dst_cls), .signaling(dst_sig)
    );

    fdiv_special_table #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_table (
        .src(src_op), .dst(dst_op), .src_cls(src_cls), .dst_cls(dst_cls),
        .src_sig(src_sig), .dst_sig(dst_sig), .result(result),
        .core_req(core_req), .snan(snan), .operr(operr), .dz(dz),
        .res_cls(res_cls), .res_sign(res_sign)
    );

    fdiv_status_pack u_pack (
        .core_req(core_req), .snan(snan), .operr(operr), .dz(dz),
        .core_ovfl(core_ovfl), .core_unfl(core_unfl), .core_inex2(core_inex2),
        .src_packed(src_packed), .src_dec_inexact(src_dec_inexact),
        .res_cls(res_cls), .res_sign(res_sign),
        .exc(exc), .cc(cc), .acc_inc(acc_inc)
    );

    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;

    // Output register, valid flag and sticky accrued byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_core_req <= 1'b0;
            out_result   <= '0;
            out_exc      <= '0;
            out_cc       <= '0;
            out_accrued  <= '0;
        end else begin
            if (fire) begin
                out_valid    <= 1'b1;
                out_core_req <= core_req;
                out_result   <= result;
                out_exc      <= exc;
                out_cc       <= cc;
                out_accrued  <= out_accrued | acc_inc;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R11
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_exc)));
    // R10
    accrued_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(out_accrued) & ~out_accrued) == '0));
    // R7
    bsun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_exc[7]);
    // R1
    core_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_core_req) |-> (out_result == '0));
    // R2
    dz_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exc[2]) |-> (!out_core_req && out_cc[1]));
endmodule

// File: tb/fdiv_exc_stage_bench.sv
`timescale 1ns/1ps
module fdiv_exc_stage_bench;
    localparam int EXP_W = 15;
    localparam int MAN_W = 64;
    localparam int OP_W  = 1 + EXP_W + MAN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic in_ready, out_valid, out_core_req;
    logic [OP_W-1:0] src_op = '0, dst_op = '0, out_result;
    logic src_packed = 0, src_dec_inexact = 0, core_ovfl = 0, core_unfl = 0, core_inex2 = 0;
    logic [7:0] out_exc;
    logic [3:0] out_cc;
    logic [4:0] out_accrued;

    int n_chk = 0, n_bad = 0;
    logic [4:0] acc_model = '0;

    always #2 clk = ~clk;

    fdiv_exc_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fdiv_exc_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_op(src_op), .dst_op(dst_op), .src_packed(src_packed),
        .src_dec_inexact(src_dec_inexact), .core_ovfl(core_ovfl),
        .core_unfl(core_unfl), .core_inex2(core_inex2), .out_valid(out_valid),
        .out_ready(out_ready), .out_core_req(out_core_req), .out_result(out_result),
        .out_exc(out_exc), .out_cc(out_cc), .out_accrued(out_accrued)
    );

    task automatic check(input string req, input logic [OP_W-1:0] act, input logic [OP_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // class codes: 0 in-range, 1 zero, 2 inf, 3 nan
    function automatic logic [OP_W-1:0] mk(input int c, input bit s, input bit sig);
        logic [63:0] r;
        r = {$urandom, $urandom};
        case (c)
            0: begin
                if (($urandom % 8) == 0) return {s, 15'h0, 1'b0, r[62:1], 1'b1};
                return {s, 15'(1 + ($urandom % 32766)), 1'b1, r[62:0]};
            end
            1: return {s, 15'h0, 64'h0};
            2: return {s, 15'h7fff, r[63], 63'h0};
            default: begin
                if (sig) return {s, 15'h7fff, r[63], 1'b0, r[61:1], 1'b1};
                return {s, 15'h7fff, r[63], 1'b1, r[61:0]};
            end
        endcase
    endfunction

    function automatic int cls_of(input logic [OP_W-1:0] v);
        if (v[78:64] == 15'h7fff) return (v[62:0] == '0) ? 2 : 3;
        if (v[78:64] == 15'h0 && v[63:0] == '0) return 1;
        return 0;
    endfunction

    function automatic void model(input logic [OP_W-1:0] s, input logic [OP_W-1:0] d,
                                  input bit pk, input bit di, input bit ov, input bit un, input bit i2,
                                  output logic [OP_W-1:0] r, output bit core,
                                  output logic [7:0] e, output logic [3:0] cc);
        int sc, dc, rc;
        bit xs, rs, sn, op, dzf;
        sc = cls_of(s); dc = cls_of(d);
        xs = s[79] ^ d[79];
        r = '0; core = 0; sn = 0; op = 0; dzf = 0; rs = xs; rc = 0;
        if (sc == 3 || dc == 3) begin
            sn = (sc == 3 && !s[62]) || (dc == 3 && !d[62]);
            r = (dc == 3) ? d : s; r[62] = 1'b1; rs = r[79]; rc = 3;
        end else if (dc == 0 && sc == 0) core = 1;
        else if (dc == 0 && sc == 1) begin r = {xs, 15'h7fff, 64'h0}; rc = 2; dzf = 1; end
        else if ((dc == 1 && sc == 1) || (dc == 2 && sc == 2)) begin
            r = {1'b0, 15'h7fff, 2'b11, 62'h0}; rc = 3; rs = 0; op = 1;
        end else if (sc == 2 || dc == 1) begin r = {xs, 79'h0}; rc = 1; end
        else begin r = {xs, 15'h7fff, 64'h0}; rc = 2; end
        e = {1'b0, sn, op, core & ov, core & un, dzf, core & i2, pk & di};
        cc = {rs, rc == 1, rc == 2, rc == 3};
    endfunction

    function automatic logic [4:0] acc_of(input logic [7:0] e);
        return {e[6] | e[5], e[4], e[3] | e[1], e[2], e[0] | e[1] | e[4]};
    endfunction

    task automatic drive(input logic [OP_W-1:0] s, input logic [OP_W-1:0] d,
                         input bit pk, input bit di, input bit ov, input bit un, input bit i2);
        src_op = s; dst_op = d; src_packed = pk; src_dec_inexact = di;
        core_ovfl = ov; core_unfl = un; core_inex2 = i2;
    endtask

    // One operation through the stage; checks every output field.
    task automatic run_op(input logic [OP_W-1:0] s, input logic [OP_W-1:0] d,
                          input bit pk, input bit di, input bit ov, input bit un, input bit i2,
                          input string tag);
        logic [OP_W-1:0] er; bit ecore; logic [7:0] ee; logic [3:0] ecc;
        model(s, d, pk, di, ov, un, i2, er, ecore, ee, ecc);
        @(negedge clk);
        drive(s, d, pk, di, ov, un, i2);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        acc_model = acc_model | acc_of(ee);
        check({tag, " R11 valid"}, OP_W'(out_valid), OP_W'(1));
        check({tag, " R1 core_req"}, OP_W'(out_core_req), OP_W'(ecore));
        check({tag, " R2/R3/R4/R5/R6 result"}, out_result, er);
        check({tag, " R7/R8 exc"}, OP_W'(out_exc), OP_W'(ee));
        check({tag, " R9 cc"}, OP_W'(out_cc), OP_W'(ecc));
        check({tag, " R10 accrued"}, OP_W'(out_accrued), OP_W'(acc_model));
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R11 actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state, R10 accrued cleared
        check("R11 reset valid", OP_W'(out_valid), OP_W'(0));
        check("R11 reset ready", OP_W'(in_ready), OP_W'(1));
        check("R10 reset accrued", OP_W'(out_accrued), OP_W'(0));

        // Full class-pair sweep with both signs; core flags held high (R7)
        for (int dc = 0; dc < 4; dc++)
            for (int sc = 0; sc < 4; sc++)
                for (int sg = 0; sg < 4; sg++)
                    run_op(mk(sc, sg[0], 1'b0), mk(dc, sg[1], 1'b0), 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "sweep");

        // NaN ordering and signaling (R6)
        for (int k = 0; k < 4; k++) begin
            run_op(mk(3, 1'b0, k[0]), mk(3, 1'b1, k[1]), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 both nan");
            run_op(mk(3, 1'b1, k[0]), mk(k[1] ? 2 : 0, 1'b0, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 src nan");
        end

        // Packed decimal inexact (R8) on special and core pairs
        run_op(mk(1, 0, 0), mk(0, 0, 0), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 packed");
        run_op(mk(0, 0, 0), mk(0, 1, 0), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 unpacked");
        run_op(mk(0, 1, 0), mk(0, 1, 0), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 core unfl");

        // Stall: held output, second pair not taken until released (R11)
        begin
            logic [OP_W-1:0] ra, sb, db, eb; bit ec; logic [7:0] ea, ebx; logic [3:0] ca, cb;
            logic [OP_W-1:0] sa, da;
            sa = mk(1, 0, 0); da = mk(0, 1, 0);
            sb = mk(2, 0, 0); db = mk(2, 0, 0);
            model(sa, da, 0, 0, 0, 0, 0, ra, ec, ea, ca);
            model(sb, db, 0, 0, 0, 0, 0, eb, ec, ebx, cb);
            @(negedge clk);
            out_ready = 1'b0;
            drive(sa, da, 0, 0, 0, 0, 0); in_valid = 1'b1;
            @(posedge clk); @(negedge clk);
            drive(sb, db, 0, 0, 0, 0, 0);
            check("R11 stall not ready", OP_W'(in_ready), OP_W'(0));
            @(posedge clk); @(negedge clk);
            check("R11 stall held", out_result, ra);
            check("R11 stall valid", OP_W'(out_valid), OP_W'(1));
            out_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            check("R11 after release", out_result, eb);
            acc_model = acc_model | acc_of(ea) | acc_of(ebx);
            check("R10 accrued after stall", OP_W'(out_accrued), OP_W'(acc_model));
            @(posedge clk); @(negedge clk);
            check("R11 drained", OP_W'(out_valid), OP_W'(0));
        end

        // Reset clears accrued (R10)
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        acc_model = '0;
        check("R10 reset clears accrued", OP_W'(out_accrued), OP_W'(0));

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            int pc;
            pc = $urandom % 10;
            run_op(mk(pc < 5 ? 0 : int'($urandom % 4), 1'($urandom), 1'($urandom)),
                   mk(pc < 3 ? 0 : int'($urandom % 4), 1'($urandom), 1'($urandom)),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "random");
        end

        finish_run();
    end
endmodule